// File: doc/BRIEF.md
# Pulse-Verify Programming Sequencer

This controller writes a memory image into a memory whose cells can only be cleared from one to zero. It goes through the addresses in ascending order. For each word it fetches the intended value from an image source. It then applies fixed-width program strobes, reading the word back after every strobe. A word that reads back correctly moves the sequencer to the next address. A word that is still wrong after the pulse cap stops the run with a failure and records the address. Words whose image value is all ones need no programming, so they get no strobe.

Once every address has been handled, the sequencer reads the whole array a second time with the supply select set to the verify level. Every word is compared with the image again. The run ends with `done` only if every location matches. Otherwise it ends with `fail`, and `fail_addr` holds the first address that did not match. Both flags stay set until the next `start`.

Top module: `pvprog_seq`

## Requirements
- R1: During and after reset, `busy`, `done`, `fail`, `img_req` and `mem_oe` are 0, `prog_n` is 1 and `vsel` is 2'b00.
- R2: A `start` seen while idle clears `done` and `fail` and raises `busy`. In the next cycle `img_req` is 1 with `img_addr` = `mem_addr` = 0. Addresses are then visited in ascending order, and every word fetch is a one-cycle `img_req`.
- R3: `img_data` is sampled one cycle after `img_req`. It is then driven on `mem_wdata` for every program strobe at that address.
- R4: A program strobe holds `prog_n` low for exactly PW = (CLK_HZ/1000)*PULSE_US/1000 cycles. Throughout the programming phase `vsel` is 2'b01 (elevated supply).
- R5: `prog_n` low and `mem_oe` high never occur in the same cycle. A cycle with both inactive separates the end of a strobe from the read that follows it, and separates the read from the next strobe.
- R6: After every strobe, the word is read with `mem_oe` high for one cycle and compared with the image. A match moves to the next address. A mismatch leads to another strobe.
- R7: If a word still mismatches after MAX_PULSES strobes, the sequencer sets `fail`, loads `fail_addr` with that address, drops `busy`, and programs no further address.
- R8: A word whose image value is all ones gets no strobe in the programming phase, and it is still compared in the final pass.
- R9: After the last address, a final pass reads every address in ascending order with `vsel` = 2'b10 (verify level), and no strobe occurs during the pass. Each address takes a fetch cycle, a load cycle and a read cycle.
- R10: A mismatch in the final pass sets `fail` with that address and ends the run. `done` is set only when all words match, and `done` and `fail` are never both 1.
- R11: `done` and `fail` hold their values while idle until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a programming run (used only while idle) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished with every word correct |
| fail | output | 1 | Last run stopped on a bad word |
| fail_addr | output | AW | Address of the bad word |
| img_req | output | 1 | Image word request |
| img_addr | output | AW | Address of the requested image word |
| img_data | input | DW | Image word, valid the cycle after `img_req` |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Data presented for programming |
| mem_rdata | input | DW | Read-back data, valid while `mem_oe` is high |
| prog_n | output | 1 | Program strobe, active low |
| mem_oe | output | 1 | Read-back enable, active high |
| vsel | output | 2 | Supply select: 00 idle, 01 programming, 10 final verify |

## Verification
Two situations are hard to reach from the ports. One is a word that needs exactly MAX_PULSES strobes, which must still pass. The other is a failure in the final pass, where the word was already accepted during programming. The bench memory model gives each address a count of strobes it takes before its bits clear, so the pulse cap can be approached from either side. The memory also corrupts one chosen word, but only on reads made at the verify supply level. The chosen word is an all-ones word, so the final pass alone must catch it.

// File: rtl/pvprog_seq.sv
module pvprog_seq #(
  parameter int AW         = 18,
  parameter int DW         = 16,
  parameter int CLK_HZ     = 100_000_000,
  parameter int PULSE_US   = 100,
  parameter int MAX_PULSES = 25
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic          img_req,
  output logic [AW-1:0] img_addr,
  input  logic [DW-1:0] img_data,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          prog_n,
  output logic          mem_oe,
  output logic [1:0]    vsel
);
  localparam int PW_RAW = (CLK_HZ / 1000) * PULSE_US / 1000;
  localparam int PW     = (PW_RAW < 1) ? 1 : PW_RAW;
  localparam int TW     = $clog2(PW + 1);
  localparam int CW     = $clog2(MAX_PULSES + 1);
  localparam logic [AW-1:0] LAST = {AW{1'b1}};

  typedef enum logic [3:0] {
    S_IDLE, S_FETCH, S_LOAD, S_GAP1, S_PULSE, S_GAP2, S_VERIFY,
    S_VFETCH, S_VLOAD, S_VREAD
  } state_t;

  state_t        state;
  logic [AW-1:0] addr;
  logic [DW-1:0] word;
  logic [CW-1:0] pcnt;
  logic [TW-1:0] tcnt;

  wire in_final = (state == S_VFETCH) || (state == S_VLOAD) || (state == S_VREAD);

  assign busy      = state != S_IDLE;
  assign img_req   = (state == S_FETCH) || (state == S_VFETCH);
  assign img_addr  = addr;
  assign mem_addr  = addr;
  assign mem_wdata = word;
  assign prog_n    = state != S_PULSE;
  assign mem_oe    = (state == S_VERIFY) || (state == S_VREAD);
  assign vsel      = !busy ? 2'b00 : (in_final ? 2'b10 : 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      addr      <= '0;
      word      <= '0;
      pcnt      <= '0;
      tcnt      <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      case (state)
        S_IDLE:
          if (start) begin
            done  <= 1'b0;
            fail  <= 1'b0;
            addr  <= '0;
            state <= S_FETCH;
          end
        S_FETCH: state <= S_LOAD;
        S_LOAD: begin
          word <= img_data;
          pcnt <= '0;
          if (img_data == {DW{1'b1}}) begin
            if (addr == LAST) begin
              addr  <= '0;
              state <= S_VFETCH;
            end else begin
              addr  <= addr + 1'b1;
              state <= S_FETCH;
            end
          end else begin
            state <= S_GAP1;
          end
        end
        S_GAP1: begin
          tcnt  <= '0;
          state <= S_PULSE;
        end
        S_PULSE: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == TW'(PW - 1)) begin
            pcnt  <= pcnt + 1'b1;
            state <= S_GAP2;
          end
        end
        S_GAP2: state <= S_VERIFY;
        S_VERIFY:
          if (mem_rdata == word) begin
            if (addr == LAST) begin
              addr  <= '0;
              state <= S_VFETCH;
            end else begin
              addr  <= addr + 1'b1;
              state <= S_FETCH;
            end
          end else if (pcnt == CW'(MAX_PULSES)) begin
            fail      <= 1'b1;
            fail_addr <= addr;
            state     <= S_IDLE;
          end else begin
            state <= S_GAP1;
          end
        S_VFETCH: state <= S_VLOAD;
        S_VLOAD: begin
          word  <= img_data;
          state <= S_VREAD;
        end
        S_VREAD:
          if (mem_rdata != word) begin
            fail      <= 1'b1;
            fail_addr <= addr;
            state     <= S_IDLE;
          end else if (addr == LAST) begin
            done  <= 1'b1;
            state <= S_IDLE;
          end else begin
            addr  <= addr + 1'b1;
            state <= S_VFETCH;
          end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pvprog_seq_chk.sv
module pvprog_seq_chk #(
  parameter int CLK_HZ   = 100_000_000,
  parameter int PULSE_US = 100
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       fail,
  input logic       prog_n,
  input logic       mem_oe,
  input logic [1:0] vsel
);
  localparam int PW_RAW = (CLK_HZ / 1000) * PULSE_US / 1000;
  localparam int PW     = (PW_RAW < 1) ? 1 : PW_RAW;

  int lowcnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lowcnt <= 0;
    else if (!prog_n) lowcnt <= lowcnt + 1;
    else lowcnt <= 0;
  end

  assert_pulse_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prog_n) |-> lowcnt == PW);
  assert_pulse_vsel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_n |-> vsel == 2'b01);
  assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!prog_n && mem_oe));
  assert_gap_before_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe) |-> $past(prog_n));
  assert_gap_before_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prog_n) |-> $past(!mem_oe));
  assert_stop_on_fail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> !busy);
  assert_final_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    vsel == 2'b10 |-> prog_n && busy);
  assert_flags_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
endmodule

bind pvprog_seq pvprog_seq_chk #(.CLK_HZ(CLK_HZ), .PULSE_US(PULSE_US)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail),
  .prog_n(prog_n), .mem_oe(mem_oe), .vsel(vsel)
);

// File: tb/pvprog_seq_test.sv
module pvprog_seq_test;
  localparam int AW = 3, DW = 16, MAXP = 4, PW = 10, N = 8;

  logic clk = 0, rst_n = 0, start = 0;
  logic busy, done, fail, img_req, prog_n, mem_oe;
  logic [AW-1:0] fail_addr, img_addr, mem_addr;
  logic [DW-1:0] img_data, mem_wdata, mem_rdata;
  logic [1:0] vsel;

  always #5 clk = ~clk;

  pvprog_seq #(.AW(AW), .DW(DW), .CLK_HZ(100_000), .PULSE_US(100), .MAX_PULSES(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
    .fail_addr(fail_addr), .img_req(img_req), .img_addr(img_addr), .img_data(img_data),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .prog_n(prog_n), .mem_oe(mem_oe), .vsel(vsel));

  logic [DW-1:0] img [N];
  logic [DW-1:0] mem [N];
  int need [N];
  int rem [N];
  int disturb = -1;
  logic prev_pn = 1;
  logic [DW-1:0] img_q = '0;

  always @(posedge clk) if (img_req) img_q <= img[img_addr];
  assign img_data = img_q;
  assign mem_rdata = (vsel == 2'b10 && int'(mem_addr) == disturb) ?
                     (mem[mem_addr] & ~16'h0100) : mem[mem_addr];

  always @(negedge clk) begin
    if (prev_pn && !prog_n) begin
      rem[mem_addr] = rem[mem_addr] - 1;
      if (rem[mem_addr] == 0) mem[mem_addr] = mem[mem_addr] & mem_wdata;
    end
    prev_pn = prog_n;
  end

  int checks = 0, failures = 0, cyc = 0;
  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h t=%0t", r, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // expected outputs for the current cycle
  logic mon = 0;
  logic e_busy, e_req, e_pn, e_oe, e_done, e_fail;
  logic [1:0] e_vs;
  int e_a;

  always @(negedge clk) if (mon) begin
    chk("R7 busy", busy, e_busy);
    chk("R2 img_req", img_req, e_req);
    chk("R4 prog_n", prog_n, e_pn);
    chk("R6 mem_oe", mem_oe, e_oe);
    chk("R9 vsel", vsel, e_vs);
    chk("R11 done", done, e_done);
    chk("R10 fail", fail, e_fail);
    chk("R5 exclusive", (!prog_n && mem_oe), 0);
    if (e_busy) begin
      chk("R2 mem_addr", mem_addr, e_a);
      chk("R2 img_addr", img_addr, e_a);
    end
    if (!e_pn) chk("R3 mem_wdata", mem_wdata, img[e_a]);
  end

  task automatic step(logic rq, logic pn, logic oe, logic [1:0] vs, int a);
    e_busy = 1; e_req = rq; e_pn = pn; e_oe = oe; e_vs = vs; e_a = a;
    e_done = 0; e_fail = 0;
    @(posedge clk); #1;
  endtask

  task automatic run(output bit ok, output int bad);
    ok = 1; bad = 0;
    for (int a = 0; a < N; a++) begin
      step(1, 1, 0, 2'b01, a);
      step(0, 1, 0, 2'b01, a);
      if (img[a] == 16'hFFFF) continue;  // R8 no strobe
      for (int p = 0; p < MAXP; p++) begin
        step(0, 1, 0, 2'b01, a);
        for (int k = 0; k < PW; k++) step(0, 0, 0, 2'b01, a);
        step(0, 1, 0, 2'b01, a);
        step(0, 1, 1, 2'b01, a);
        if (p + 1 >= need[a]) break;
      end
      if (need[a] > MAXP) begin ok = 0; bad = a; return; end
    end
    for (int a = 0; a < N; a++) begin
      step(1, 1, 0, 2'b10, a);
      step(0, 1, 0, 2'b10, a);
      step(0, 1, 1, 2'b10, a);
      if (a == disturb) begin ok = 0; bad = a; return; end
    end
  endtask

  task automatic do_test(string name);
    bit ok; int bad;
    for (int i = 0; i < N; i++) begin mem[i] = '1; rem[i] = need[i]; end
    @(negedge clk) start = 1;
    @(posedge clk); #1; start = 0;
    mon = 1;
    run(ok, bad);
    e_busy = 0; e_req = 0; e_pn = 1; e_oe = 0; e_vs = 2'b00;
    e_done = ok; e_fail = !ok;
    repeat (3) @(negedge clk);
    mon = 0;
    chk({"R10/R7 fail_addr ", name}, ok ? 0 : fail_addr, ok ? 0 : bad);
    chk({"R11 done held ", name}, done, ok);
    for (int i = 0; i < N; i++)
      if (ok || i < bad) chk({"R6 memory word ", name}, mem[i], img[i]);
  endtask

  initial begin
    img = '{16'h1234, 16'hFFFF, 16'h0000, 16'hABCD, 16'hFFFF, 16'h7F7F, 16'h0001, 16'h8000};
    need = '{1, 0, 3, MAXP, 0, 2, 1, 1};
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
    chk("R1 prog_n", prog_n, 1);
    chk("R1 mem_oe", mem_oe, 0);
    chk("R1 img_req", img_req, 0);
    chk("R1 vsel", vsel, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 idle after reset", busy, 0);

    do_test("pass");                 // R4 R6 R8 boundary need==MAX passes
    need[5] = MAXP + 1;
    do_test("cap");                  // R7 fail at address 5
    need[5] = 2;
    disturb = 4;
    do_test("final");                // R9 R10 skipped word caught in final pass
    disturb = -1;
    do_test("again");                // R11 start clears fail
    repeat (5) @(negedge clk);
    chk("R11 done stays", done, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule